// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

The block turns a stream of PCM words into a time-division serial frame. It produces its own bit clock, a frame sync and a serial data line. The bit clock is the system clock divided by a programmable amount. Each frame holds one or two slots, and each slot carries one word of 8 to 32 bits. Words arrive on a valid/ready handshake. A word is taken at the start of every slot that is not masked.

Configuration inputs select the frame format:
- sync length: one bit or a whole word;
- sync placement: on the first data bit, or one bit early so that it overlaps the last bit of the previous frame;
- separate inversion of the bit clock and of the sync;
- bit order, word width, slot count and a per-slot mask.

Together these settings cover the usual I2S, left-justified and both DSP-style layouts.

Clearing the enable never cuts a frame short. Whether another frame follows is decided when the last bit of each frame starts. The block then completes that frame and returns to idle levels. The configuration fields are assumed stable while the block is active.

Top module: `tdm_frame_tx`

## Requirements
- R1: After reset, and with the enable low, `active`, `sdata`, `s_ready` and `underrun` are 0, `bclk` equals `cfg_bclk_inv` and `fsync` equals `cfg_sync_inv`.
- R2: Each half period of the bit clock lasts `cfg_div`+1 system clocks. The first rising edge (before inversion) comes `cfg_div`+1 cycles after the cycle that samples the enable high. Data and sync change only at falling edges, so they are stable at rising edges.
- R3: A frame is `cfg_slots` words of `cfg_width` bits each, with slot 0 first. A width below 8 is treated as 8 and a width above 32 as 32. A slot count of 0 is treated as 1 and a count above 2 as 2.
- R4: With `cfg_lsb_first`=0, each word is sent from bit width-1 down to bit 0. With `cfg_lsb_first`=1, it is sent from bit 0 upward.
- R5: With `cfg_sync_word`=1, the sync is active for width bit periods. With `cfg_sync_word`=0, it is active for one bit period.
- R6: With `cfg_sync_early`=0, the sync starts with bit 0 of slot 0. With `cfg_sync_early`=1, it starts one bit earlier, on the last bit of the previous frame. In that case the first frame after idle is preceded by one lead bit with data 0 and sync active, and the last bit of the final frame carries no sync.
- R7: `cfg_sync_inv`=1 makes the sync active-low. `cfg_bclk_inv`=1 inverts the bit clock, including its idle level.
- R8: Bit i of `cfg_slot_mask` masks slot i. A masked slot sends zeros, keeps `s_ready` low and takes no word.
- R9: An unmasked slot that finds `s_valid` low sends zeros. `underrun` is then high for exactly one cycle, the cycle after the slot's `s_ready` cycle, while `s_ready` is still raised at the slot start.
- R10: Exactly one word is accepted per unmasked slot, in the single cycle where `s_ready` is high. `s_ready` is never high while idle with the enable low.
- R11: If the enable is high when the last bit of a frame begins, another frame follows. Otherwise the block finishes that frame and stops. `active` stays 1 until then.
- R12: Whenever `active` is 0, the outputs sit at their idle levels: `sdata`=0, `bclk`=`cfg_bclk_inv`, `fsync`=`cfg_sync_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Run request |
| cfg_div | input | DIV_W | Half bit period minus one, in system clocks |
| cfg_width | input | clog2(MAX_WIDTH+1) | Word width in bits |
| cfg_slots | input | clog2(MAX_SLOTS+1) | Slots per frame |
| cfg_slot_mask | input | MAX_SLOTS | Set bit masks that slot |
| cfg_sync_word | input | 1 | 1: sync one word long, 0: one bit |
| cfg_sync_early | input | 1 | 1: sync one bit before the first data bit |
| cfg_sync_inv | input | 1 | 1: active-low sync |
| cfg_bclk_inv | input | 1 | 1: inverted bit clock |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| s_valid | input | 1 | Input word valid |
| s_data | input | MAX_WIDTH | Input word, right-aligned |
| s_ready | output | 1 | Word accepted this cycle if valid |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse on a starved slot |
| active | output | 1 | High while frames are being sent |

## Verification
The bit clock edges are due `cfg_div`+1 system clocks apart, counted from the cycle that samples the enable. The bench samples `bclk` at falling system-clock edges exactly four and five cycles after that cycle, using a divider of 3. The serial data and sync for a bit are valid at the rising bit-clock edge inside that bit. The bench therefore records both at every rising edge it sees and compares the whole frame stream bit by bit against a stream built from the requirements.

Three results follow a slot start by a fixed count:
- `underrun` rises one cycle after the slot start.
- The word is accepted in the slot-start cycle itself.
- `active` falls in the cycle after the final bit period ends.

Per-edge counters gather the first two, and the third is awaited before the idle levels are checked.

// File: rtl/tdm_tx_pkg.sv
// Package tdm_tx_pkg
// Shared constants and the format bundle of the serial frame transmitter.
// Assumes nothing beyond being compiled before the modules that import it.
package tdm_tx_pkg;

    // Smallest word width the transmitter will send.
    localparam int unsigned TDM_MIN_WIDTH = 8;

    // Format switches that shape the sync and the bit order.
    typedef struct packed {
        logic sync_word;
        logic sync_early;
        logic sync_inv;
        logic bclk_inv;
        logic lsb_first;
    } tdm_fmt_t;

endpackage

// File: rtl/tdm_bclk_div.sv
// Module tdm_bclk_div
// Divides the system clock into the internal bit clock phase.
// Holds the phase low and the counter cleared whenever run is low, so every
// run starts on a fresh bit. adv marks the last system cycle of a bit.
// Assumes div is stable while run is high.
module tdm_bclk_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half,
    output logic             adv
);

    logic [DIV_W-1:0] cnt_q;
    logic             half_q;

    // Count system clocks and flip the phase every div+1 cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (cnt_q == div) begin
            cnt_q  <= '0;
            half_q <= ~half_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign half = half_q;
    assign adv  = run && (cnt_q == div) && half_q;

endmodule

// File: rtl/tdm_frame_seq.sv
// Module tdm_frame_seq
// Walks slot and bit positions of the frame, the optional lead bit for early
// sync, and the per-frame continue decision taken when the last bit starts.
// Emits load with the slot index whenever a new slot begins.
// Assumes wlen is at least 8 and nslots is 1..MAX_SLOTS.
module tdm_frame_seq #(
    parameter int unsigned MAX_WIDTH = 32,
    parameter int unsigned MAX_SLOTS = 2,
    localparam int unsigned BIT_W  = $clog2(MAX_WIDTH),
    localparam int unsigned WLEN_W = $clog2(MAX_WIDTH + 1),
    localparam int unsigned NSL_W  = $clog2(MAX_SLOTS + 1),
    localparam int unsigned SIDX_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              early,
    input  logic [WLEN_W-1:0] wlen,
    input  logic [NSL_W-1:0]  nslots,
    input  logic              adv,
    output logic              running,
    output logic              lead,
    output logic [SIDX_W-1:0] slot,
    output logic [BIT_W-1:0]  bitpos,
    output logic              frame_last,
    output logic              cont,
    output logic              load,
    output logic [SIDX_W-1:0] load_slot
);

    logic              run_q, pre_q, cont_q;
    logic [SIDX_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;
    logic              last_bit, last_slot, start;

    assign last_bit  = (bit_q == BIT_W'(wlen - 1'b1));
    assign last_slot = (slot_q == SIDX_W'(nslots - 1'b1));
    assign start     = !run_q && en;

    // Decide whether a slot begins this cycle and which one.
    always_comb begin
        load      = 1'b0;
        load_slot = '0;
        if (start) begin
            load = !early;
        end else if (run_q && adv) begin
            if (pre_q) begin
                load = 1'b1;
            end else if (last_bit) begin
                if (!last_slot) begin
                    load      = 1'b1;
                    load_slot = SIDX_W'(slot_q + 1'b1);
                end else begin
                    load = cont_q;
                end
            end
        end
    end

    // Advance the frame position once per bit and stop at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            pre_q  <= 1'b0;
            cont_q <= 1'b0;
            slot_q <= '0;
            bit_q  <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            pre_q  <= early;
            cont_q <= 1'b1;
            slot_q <= '0;
            bit_q  <= '0;
        end else if (run_q && adv) begin
            if (pre_q) begin
                pre_q  <= 1'b0;
                slot_q <= '0;
                bit_q  <= '0;
            end else if (last_bit) begin
                bit_q <= '0;
                if (!last_slot) begin
                    slot_q <= SIDX_W'(slot_q + 1'b1);
                end else if (cont_q) begin
                    slot_q <= '0;
                end else begin
                    run_q <= 1'b0;
                end
            end else begin
                bit_q <= bit_q + 1'b1;
                if (last_slot && (bit_q == BIT_W'(wlen - 2'd2))) begin
                    cont_q <= en;
                end
            end
        end
    end

    assign running    = run_q;
    assign lead       = pre_q;
    assign slot       = slot_q;
    assign bitpos     = bit_q;
    assign frame_last = last_bit && last_slot;
    assign cont       = cont_q;

endmodule

// File: rtl/tdm_word_path.sv
// Module tdm_word_path
// Accepts a word at each unmasked slot start, substitutes zeros for masked or
// starved slots, flags starvation, and selects the bit for the current
// position in the chosen order. Assumes bitpos < wlen <= MAX_WIDTH.
module tdm_word_path #(
    parameter int unsigned MAX_WIDTH = 32,
    parameter int unsigned MAX_SLOTS = 2,
    localparam int unsigned BIT_W  = $clog2(MAX_WIDTH),
    localparam int unsigned WLEN_W = $clog2(MAX_WIDTH + 1),
    localparam int unsigned SIDX_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [SIDX_W-1:0]    load_slot,
    input  logic [MAX_SLOTS-1:0] mask,
    input  logic                 s_valid,
    input  logic [MAX_WIDTH-1:0] s_data,
    input  logic [BIT_W-1:0]     bitpos,
    input  logic [WLEN_W-1:0]    wlen,
    input  logic                 lsb_first,
    input  logic                 in_frame,
    output logic                 s_ready,
    output logic                 sdata,
    output logic                 underrun
);

    logic [MAX_WIDTH-1:0] word_q;
    logic                 und_q;
    logic                 slot_masked;
    logic [BIT_W-1:0]     sel;

    assign slot_masked = mask[load_slot];
    assign s_ready     = load && !slot_masked;

    // Capture the slot word, or zeros when the slot is masked or starved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            und_q  <= 1'b0;
        end else begin
            und_q <= 1'b0;
            if (load) begin
                if (slot_masked) begin
                    word_q <= '0;
                end else if (s_valid) begin
                    word_q <= s_data;
                end else begin
                    word_q <= '0;
                    und_q  <= 1'b1;
                end
            end
        end
    end

    // Map the time position of the bit to its index in the word.
    always_comb begin
        if (lsb_first) sel = bitpos;
        else           sel = BIT_W'(wlen - 1'b1) - bitpos;
    end

    assign sdata    = in_frame && word_q[sel];
    assign underrun = und_q;

endmodule

// File: rtl/tdm_frame_tx.sv
// Module tdm_frame_tx
// Serial audio frame transmitter: divides the system clock into a bit clock,
// sequences slots of a time-division frame, serializes handshaked words and
// generates the frame sync in the selected width, placement and polarity.
// Assumes all cfg_* fields except cfg_en are stable while active is high.
module tdm_frame_tx
    import tdm_tx_pkg::*;
#(
    parameter int unsigned MAX_WIDTH = 32,
    parameter int unsigned MAX_SLOTS = 2,
    parameter int unsigned MIN_WIDTH = TDM_MIN_WIDTH,
    parameter int unsigned DIV_W     = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_en,
    input  logic [DIV_W-1:0]                  cfg_div,
    input  logic [$clog2(MAX_WIDTH+1)-1:0]    cfg_width,
    input  logic [$clog2(MAX_SLOTS+1)-1:0]    cfg_slots,
    input  logic [MAX_SLOTS-1:0]              cfg_slot_mask,
    input  logic                              cfg_sync_word,
    input  logic                              cfg_sync_early,
    input  logic                              cfg_sync_inv,
    input  logic                              cfg_bclk_inv,
    input  logic                              cfg_lsb_first,
    input  logic                              s_valid,
    input  logic [MAX_WIDTH-1:0]              s_data,
    output logic                              s_ready,
    output logic                              bclk,
    output logic                              fsync,
    output logic                              sdata,
    output logic                              underrun,
    output logic                              active
);

    localparam int unsigned BIT_W  = $clog2(MAX_WIDTH);
    localparam int unsigned WLEN_W = $clog2(MAX_WIDTH + 1);
    localparam int unsigned NSL_W  = $clog2(MAX_SLOTS + 1);
    localparam int unsigned SIDX_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

    tdm_fmt_t          fmt;
    logic [WLEN_W-1:0] wlen;
    logic [NSL_W-1:0]  nslots;
    logic              half, adv;
    logic              running, lead, frame_last, cont, load, in_frame;
    logic [SIDX_W-1:0] slot, load_slot;
    logic [BIT_W-1:0]  bitpos;
    logic              sync_act;

    assign fmt = '{sync_word:  cfg_sync_word,
                   sync_early: cfg_sync_early,
                   sync_inv:   cfg_sync_inv,
                   bclk_inv:   cfg_bclk_inv,
                   lsb_first:  cfg_lsb_first};

    // Clamp the programmed word width into the supported range.
    always_comb begin
        if (cfg_width < WLEN_W'(MIN_WIDTH))      wlen = WLEN_W'(MIN_WIDTH);
        else if (cfg_width > WLEN_W'(MAX_WIDTH)) wlen = WLEN_W'(MAX_WIDTH);
        else                                     wlen = cfg_width;
    end

    // Clamp the programmed slot count into 1..MAX_SLOTS.
    always_comb begin
        if (cfg_slots == '0)                     nslots = NSL_W'(1);
        else if (cfg_slots > NSL_W'(MAX_SLOTS))  nslots = NSL_W'(MAX_SLOTS);
        else                                     nslots = cfg_slots;
    end

    tdm_bclk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .div   (cfg_div),
        .half  (half),
        .adv   (adv)
    );

    tdm_frame_seq #(.MAX_WIDTH(MAX_WIDTH), .MAX_SLOTS(MAX_SLOTS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_en),
        .early      (fmt.sync_early),
        .wlen       (wlen),
        .nslots     (nslots),
        .adv        (adv),
        .running    (running),
        .lead       (lead),
        .slot       (slot),
        .bitpos     (bitpos),
        .frame_last (frame_last),
        .cont       (cont),
        .load       (load),
        .load_slot  (load_slot)
    );

    assign in_frame = running && !lead;

    tdm_word_path #(.MAX_WIDTH(MAX_WIDTH), .MAX_SLOTS(MAX_SLOTS)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_slot (load_slot),
        .mask      (cfg_slot_mask),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .bitpos    (bitpos),
        .wlen      (wlen),
        .lsb_first (fmt.lsb_first),
        .in_frame  (in_frame),
        .s_ready   (s_ready),
        .sdata     (sdata),
        .underrun  (underrun)
    );

    // Decide whether the current bit period lies inside the sync window.
    always_comb begin
        sync_act = 1'b0;
        if (running) begin
            if (fmt.sync_early) begin
                sync_act = lead
                        || (in_frame && frame_last && cont)
                        || (in_frame && fmt.sync_word && (slot == '0)
                            && (bitpos != BIT_W'(wlen - 1'b1)));
            end else begin
                sync_act = in_frame && (slot == '0)
                        && (fmt.sync_word || (bitpos == '0));
            end
        end
    end

    assign fsync  = sync_act ^ fmt.sync_inv;
    assign bclk   = half ^ fmt.bclk_inv;
    assign active = running;

endmodule

// File: rtl/tdm_frame_tx_chk.sv
// Module tdm_frame_tx_chk
// Property checker for the serial frame transmitter, bound to every instance.
// Observes ports only; assumes the synchronous active-low reset of the block.
module tdm_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic cfg_sync_inv,
    input logic cfg_bclk_inv,
    input logic s_ready,
    input logic bclk,
    input logic fsync,
    input logic sdata,
    input logic underrun,
    input logic active
);

    // R12
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (sdata == 1'b0 && bclk == cfg_bclk_inv && fsync == cfg_sync_inv));

    // R9
    underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

    // R9
    underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (sdata == 1'b0 && active));

    // R10
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cfg_en) |-> !s_ready);

    // R10
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

endmodule

bind tdm_frame_tx tdm_frame_tx_chk u_tdm_frame_tx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .cfg_sync_inv (cfg_sync_inv),
    .cfg_bclk_inv (cfg_bclk_inv),
    .s_ready      (s_ready),
    .bclk         (bclk),
    .fsync        (fsync),
    .sdata        (sdata),
    .underrun     (underrun),
    .active       (active)
);

// File: tb/tdm_frame_tx_bench.sv
// Bench for tdm_frame_tx: a format vector table walked by one loop, then
// directed tests for reset, bit clock timing, starvation and full masking.
module tdm_frame_tx_bench;

    typedef struct packed {
        logic [5:0] width;
        logic [1:0] slots;
        logic [1:0] mask;
        logic       sword;
        logic       early;
        logic       sinv;
        logic       binv;
        logic       lsb;
        logic [5:0] ew;
        logic [1:0] es;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{6'd16, 2'd2, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd16, 2'd2},
        '{6'd24, 2'd2, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd24, 2'd2},
        '{6'd8,  2'd2, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd8,  2'd2},
        '{6'd32, 2'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd32, 2'd1},
        '{6'd12, 2'd2, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd12, 2'd2},
        '{6'd5,  2'd0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd8,  2'd1},
        '{6'd40, 2'd3, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd32, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic [5:0]  cfg_width = 6'd0;
    logic [1:0]  cfg_slots = 2'd0;
    logic [1:0]  cfg_slot_mask = 2'b00;
    logic        cfg_sync_word = 1'b0;
    logic        cfg_sync_early = 1'b0;
    logic        cfg_sync_inv = 1'b0;
    logic        cfg_bclk_inv = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data;
    logic        s_ready, bclk, fsync, sdata, underrun, active;

    logic [31:0] words [8];
    int          widx, take_cnt, rdy_cnt, und_cnt, cap_n;
    logic        clr = 1'b1;
    logic        prev_b, cur_b;
    logic        cap_d [256];
    logic        cap_s [256];
    logic        exp_d [256];
    logic        exp_s [256];
    int          exp_n;
    int          errors = 0;
    int          checks = 0;

    always #5 clk = ~clk;

    tdm_frame_tx u_tdm_frame_tx (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_div(cfg_div),
        .cfg_width(cfg_width), .cfg_slots(cfg_slots), .cfg_slot_mask(cfg_slot_mask),
        .cfg_sync_word(cfg_sync_word), .cfg_sync_early(cfg_sync_early),
        .cfg_sync_inv(cfg_sync_inv), .cfg_bclk_inv(cfg_bclk_inv),
        .cfg_lsb_first(cfg_lsb_first), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .bclk(bclk), .fsync(fsync), .sdata(sdata),
        .underrun(underrun), .active(active)
    );

    assign s_data = words[widx[2:0]];

    // Handshake and starvation counters at the active edge.
    always @(posedge clk) begin
        if (clr) begin
            widx <= 0; take_cnt <= 0; rdy_cnt <= 0; und_cnt <= 0;
        end else begin
            if (s_ready) rdy_cnt <= rdy_cnt + 1;
            if (s_ready && s_valid) begin
                widx     <= widx + 1;
                take_cnt <= take_cnt + 1;
            end
            if (underrun) und_cnt <= und_cnt + 1;
        end
    end

    // Record data and sync (active-high view) at each rising bit clock edge.
    always @(negedge clk) begin
        cur_b = bclk ^ cfg_bclk_inv;
        if (clr) begin
            cap_n <= 0;
        end else if (cur_b && !prev_b && cap_n < 256) begin
            cap_d[cap_n] <= sdata;
            cap_s[cap_n] <= fsync ^ cfg_sync_inv;
            cap_n <= cap_n + 1;
        end
        prev_b <= cur_b;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected stream for F frames with a word always available.
    task automatic build_exp(input vec_t v, input int nfr);
        int          wi;
        int          w_n;
        int          s_n;
        logic [31:0] w;
        wi = 0; exp_n = 0;
        w_n = int'(v.ew); s_n = int'(v.es);
        if (v.early) begin
            exp_d[exp_n] = 1'b0; exp_s[exp_n] = 1'b1; exp_n++;
        end
        for (int f = 0; f < nfr; f++) begin
            for (int s = 0; s < s_n; s++) begin
                if (v.mask[s]) w = 32'h0;
                else begin w = words[wi % 8]; wi++; end
                for (int b = 0; b < w_n; b++) begin
                    exp_d[exp_n] = v.lsb ? w[b] : w[w_n-1-b];
                    if (v.early)
                        exp_s[exp_n] = (v.sword && s == 0 && b != w_n-1)
                                    || (s == s_n-1 && b == w_n-1 && f < nfr-1);
                    else
                        exp_s[exp_n] = (s == 0) && (v.sword || b == 0);
                    exp_n++;
                end
            end
        end
    endtask

    task automatic apply_cfg(input vec_t v, input logic [7:0] div);
        @(negedge clk);
        cfg_width = v.width; cfg_slots = v.slots; cfg_slot_mask = v.mask;
        cfg_sync_word = v.sword; cfg_sync_early = v.early;
        cfg_sync_inv = v.sinv; cfg_bclk_inv = v.binv; cfg_lsb_first = v.lsb;
        cfg_div = div;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Enable, capture need bits, drop the enable, wait for the stop.
    task automatic run_until(input int need);
        cfg_en = 1'b1;
        while (cap_n < need) @(negedge clk);
        @(negedge clk);
        cfg_en = 1'b0;
        @(negedge clk);
        chk(active == 1'b1, "R11 active held after enable cleared", int'(active), 1);
        while (active) @(negedge clk);
        @(negedge clk);
        chk(bclk == cfg_bclk_inv && fsync == cfg_sync_inv && sdata == 1'b0,
            "R12 idle levels after stop", {29'd0, bclk, fsync, sdata},
            {29'd0, cfg_bclk_inv, cfg_sync_inv, 1'b0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) words[i] = 32'hA5C3_0F01 + i * 32'h1357_9BDF;

        // R1 reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(active == 1'b0 && s_ready == 1'b0 && underrun == 1'b0,
            "R1 active/ready/underrun after reset",
            {29'd0, active, s_ready, underrun}, 0);
        chk(bclk == 1'b0 && fsync == 1'b0 && sdata == 1'b0,
            "R1 line levels after reset", {29'd0, bclk, fsync, sdata}, 0);
        clr = 1'b0;

        // Vector table: R3 R4 R5 R6 R7 stream, R8 R10 takes, R11 frame count
        for (int k = 0; k < NVEC; k++) begin
            int pre;
            int unmasked;
            int nb;
            int bad;
            int first;
            vec_t v;
            v = VECS[k];
            pre = v.early ? 1 : 0;
            unmasked = 0;
            for (int s = 0; s < int'(v.es); s++) if (!v.mask[s]) unmasked++;
            nb = int'(v.ew) * int'(v.es);
            s_valid = 1'b1;
            apply_cfg(v, 8'd0);
            run_until(pre + 2 * nb);
            build_exp(v, 3);
            chk(cap_n == exp_n, $sformatf("R11 R3 bit count vector %0d", k), cap_n, exp_n);
            bad = 0; first = -1;
            for (int i = 0; i < exp_n; i++)
                if (cap_d[i] !== exp_d[i]) begin bad++; if (first < 0) first = i; end
            chk(bad == 0, $sformatf("R3 R4 R8 data stream vector %0d first bad bit %0d",
                k, first), bad, 0);
            bad = 0; first = -1;
            for (int i = 0; i < exp_n; i++)
                if (cap_s[i] !== exp_s[i]) begin bad++; if (first < 0) first = i; end
            chk(bad == 0, $sformatf("R5 R6 R7 sync stream vector %0d first bad bit %0d",
                k, first), bad, 0);
            chk(take_cnt == 3 * unmasked, $sformatf("R10 R8 words taken vector %0d", k),
                take_cnt, 3 * unmasked);
            chk(und_cnt == 0, $sformatf("R9 no underrun with data vector %0d", k), und_cnt, 0);
        end

        // R2 bit clock timing with divider 3
        begin
            vec_t v;
            v = '{6'd8, 2'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd8, 2'd1};
            apply_cfg(v, 8'd3);
            cfg_en = 1'b1;
            repeat (4) @(posedge clk);
            @(negedge clk);
            chk(bclk == 1'b0, "R2 bclk low 4 cycles after enable", int'(bclk), 0);
            @(posedge clk); @(negedge clk);
            chk(bclk == 1'b1, "R2 bclk rises 4 cycles after enable", int'(bclk), 1);
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(bclk == 1'b1, "R2 bclk high for 4 cycles", int'(bclk), 1);
            @(posedge clk); @(negedge clk);
            chk(bclk == 1'b0, "R2 bclk falls after 4 cycles", int'(bclk), 0);
            cfg_en = 1'b0;
            while (active) @(negedge clk);
            chk(cap_n == 8, "R11 single frame when enable cleared early", cap_n, 8);
        end

        // R9 starvation: no valid words, two frames
        begin
            vec_t v;
            int bad;
            v = '{6'd8, 2'd2, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd8, 2'd2};
            s_valid = 1'b0;
            apply_cfg(v, 8'd0);
            run_until(16);
            chk(und_cnt == 4, "R9 underrun pulses per starved slot", und_cnt, 4);
            chk(rdy_cnt == 4, "R9 ready raised at starved slot starts", rdy_cnt, 4);
            bad = 0;
            for (int i = 0; i < cap_n; i++) if (cap_d[i] !== 1'b0) bad++;
            chk(bad == 0 && cap_n == 32, "R9 zeros sent while starved", bad, 0);
        end

        // R8 both slots masked: no ready, no words, zeros
        begin
            vec_t v;
            int bad;
            v = '{6'd8, 2'd2, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd8, 2'd2};
            s_valid = 1'b1;
            apply_cfg(v, 8'd0);
            run_until(17);
            chk(rdy_cnt == 0 && take_cnt == 0, "R8 masked slots take no word",
                rdy_cnt + take_cnt, 0);
            bad = 0;
            for (int i = 0; i < cap_n; i++) if (cap_d[i] !== 1'b0) bad++;
            chk(bad == 0, "R8 masked slots send zeros", bad, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule